// File: doc/BRIEF.md
# Receive-Frame Interrupt Coalescing Queue

This block sits between a set of HDLC receive channels and a host processor. Each channel raises an event strobe with an event type. The block takes one event per cycle and writes a one-word record of it into a circular queue in memory. It steps a next-slot pointer through that ring, wrapping at any slot whose wrap bit is set. The host consumes records and clears their valid bits. A record is never written over a slot the host still owns. In that case the event is dropped and a one-cycle overflow pulse is raised.

Every logged event gets a queue record, but the interrupt line is throttled. A shared down-counter counts logged frame-received events across all channels. When the count reaches the programmed threshold, the block sets a level interrupt and reloads the counter from the current threshold. The host can rewrite the threshold at any time, and the new value is used from the next reload. The host clears the interrupt by writing one to the acknowledge input.

Top module: `rxf_coalesce_queue`

## Requirements
- R1: Each accepted event whose target slot is free produces exactly one memory write in that cycle. The write goes to the current pointer with data bit 31 = 1 (valid), bit 30 = the slot's wrap bit, bits 17:16 = the event type, bits 7:0 = the channel number, and all other bits 0.
- R2: At most one event is accepted per cycle. It is the lowest-numbered channel whose strobe is high, and its `ev_accept` bit is set. All other pending channels see `ev_accept` low and must hold their strobe.
- R3: If `slot_busy` is high when an event is accepted, there is no memory write and `ovf_pulse` is high for that cycle. The pointer and the frame counter keep their values.
- R4: After a logged event the pointer advances by 4 bytes. If `slot_wrap` was high for that slot, the pointer returns to the queue base instead.
- R5: At reset the frame counter holds the reset threshold (3). Only logged events of type 0 (frame received) decrement it. Types 1 to 3 leave it unchanged.
- R6: The logged type-0 event that completes the threshold count sets `irq` on the next clock edge. The counter reloads from the threshold register on that same edge.
- R7: A threshold write (`cfg_sel` = 2) does not change the current count. The new value is used only from the next reload.
- R8: `irq` stays high until an `irq_ack` pulse in a cycle where no new threshold is reached. A reach in the same cycle as an acknowledge, or while `irq` is already high, leaves it high.
- R9: A config write with `cfg_sel` = 0 loads the queue base and `cfg_sel` = 1 loads the pointer. A pointer load takes priority over a same-cycle advance.
- R10: After reset `irq`, `mem_we`, `ovf_pulse` and `ev_accept` are low, and `mem_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | NCH | Per-channel event strobe, held until accepted |
| ev_type | input | NCH*2 | Per-channel event type, channel c in bits 2c+1:2c; 0 = frame received |
| ev_accept | output | NCH | One-hot grant to the accepted channel |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 2 | 0 = queue base, 1 = pointer, 2 = threshold |
| cfg_wdata | input | ADDR_W | Config write data (threshold uses the low CNT_W bits) |
| slot_busy | input | 1 | Valid bit read back from the slot at `mem_addr` |
| slot_wrap | input | 1 | Wrap bit read back from the slot at `mem_addr` |
| mem_we | output | 1 | Queue record write strobe |
| mem_addr | output | ADDR_W | Current slot address (next-slot pointer) |
| mem_wdata | output | 32 | Queue record data |
| ovf_pulse | output | 1 | Event dropped because the slot was busy |
| irq | output | 1 | Global coalesced interrupt, level |
| irq_ack | input | 1 | Write-one-to-clear acknowledge for `irq` |

## Verification
Arbitration and pointer movement are tried with sparse, dense and all-channel strobe masks. These show whether the lowest channel wins or some other order is used. The masks are mixed with busy and wrap slots, which show a drop apart from an advance and a wrap apart from a plain step. The counter is driven with interleaved frame and non-frame events, so miscounting of other event types shows up as an early interrupt. It is also driven with a threshold rewrite in mid-count, which shows an immediate reload apart from a deferred one. Acknowledges are placed alone, together with a reach, and after a dropped event. These cases show the set/clear priority and whether a dropped event still moves the count.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int TYPE_W = 2;
  localparam int DATA_W = 32;
  localparam logic [TYPE_W-1:0] EV_FRAME = 2'd0;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_PTR  = 2'd1,
    SEL_THR  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  // next slot address: wrap to base or step forward
  function automatic logic [31:0] slot_after(input logic [31:0] cur,
                                             input logic [31:0] base,
                                             input logic [31:0] step,
                                             input logic        wrap);
    return wrap ? base : cur + step;
  endfunction

  // count of one (or zero threshold) means this frame completes the batch
  function automatic logic batch_done(input logic [31:0] cnt);
    return cnt <= 32'd1;
  endfunction

  function automatic logic [31:0] count_after(input logic [31:0] cnt,
                                              input logic [31:0] thr);
    return batch_done(cnt) ? thr : cnt - 32'd1;
  endfunction

  function automatic logic [DATA_W-1:0] pack_entry(input logic [7:0]        ch,
                                                   input logic [TYPE_W-1:0] ty,
                                                   input logic              wrap);
    logic [DATA_W-1:0] e;
    e        = '0;
    e[31]    = 1'b1;
    e[30]    = wrap;
    e[17:16] = ty;
    e[7:0]   = ch;
    return e;
  endfunction
endpackage

// File: rtl/rxq_arbiter.sv
module rxq_arbiter #(
  parameter int NCH  = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  req,
  output logic [NCH-1:0]  grant,
  output logic            any,
  output logic [CH_W-1:0] idx
);
  logic [NCH:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NCH; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];

    if (i > 0) begin : g_chk
      localparam logic [NCH-1:0] LOWER = NCH'((1 << i) - 1);
      // R2: a grant never goes past a pending lower channel
      assert_lowest_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant[i] |-> ((req & LOWER) == '0));
    end
  end

  assign any = seen[NCH];

  always_comb begin
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (grant[i]) idx = CH_W'(i);
    end
  end

  // R2: some request pending means exactly one grant
  assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> ($countones(grant) == 1));
endmodule

// File: rtl/rxq_slot_ptr.sv
module rxq_slot_ptr #(
  parameter int ADDR_W = 16,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic              ptr_we,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              adv,
  input  logic              wrap,
  output logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] base
);
  import rxq_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      base <= '0;
    end else begin
      if (base_we) base <= wdata;
      if (ptr_we)
        ptr <= wdata;
      else if (adv)
        ptr <= ADDR_W'(slot_after(32'(ptr), 32'(base), 32'(STEP), wrap));
    end
  end

  assert_wrap_to_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wrap && !ptr_we && !base_we) |=> (ptr == $past(base)));
  assert_step_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wrap && !ptr_we) |=> (ptr == ADDR_W'($past(ptr) + STEP)));
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !ptr_we) |=> $stable(ptr));
  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> (ptr == $past(wdata)));
endmodule

// File: rtl/rxq_frame_gate.sv
module rxq_frame_gate #(
  parameter int CNT_W   = 8,
  parameter int THR_RST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_we,
  input  logic [CNT_W-1:0] thr_wdata,
  input  logic             frame_tick,
  input  logic             ack,
  output logic             reach,
  output logic             irq
);
  import rxq_pkg::*;

  logic [CNT_W-1:0] thr_q;
  logic [CNT_W-1:0] cnt_q;

  assign reach = frame_tick && batch_done(32'(cnt_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= CNT_W'(THR_RST);
      cnt_q <= CNT_W'(THR_RST);
      irq   <= 1'b0;
    end else begin
      if (thr_we) thr_q <= thr_wdata;
      if (frame_tick) cnt_q <= CNT_W'(count_after(32'(cnt_q), 32'(thr_q)));
      if (reach)
        irq <= 1'b1;
      else if (ack)
        irq <= 1'b0;
    end
  end

  assert_idle_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(cnt_q));
  assert_reach_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reach |=> irq);
  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reach |=> (cnt_q == $past(thr_q)));
  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);
  assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !reach) |=> !irq);
endmodule

// File: rtl/rxf_coalesce_queue.sv
module rxf_coalesce_queue #(
  parameter int NCH     = 4,
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 8,
  parameter int THR_RST = 3,
  localparam int TW     = rxq_pkg::TYPE_W,
  localparam int DW     = rxq_pkg::DATA_W,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int STEP   = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ev_valid,
  input  logic [NCH*TW-1:0] ev_type,
  output logic [NCH-1:0]    ev_accept,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              slot_busy,
  input  logic              slot_wrap,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              ovf_pulse,
  output logic              irq,
  input  logic              irq_ack
);
  import rxq_pkg::*;

  logic            pick_any;
  logic [CH_W-1:0] pick_idx;
  logic [TW-1:0]   pick_type;
  logic            log_ev;
  logic            drop_ev;
  logic            frame_tick;
  logic            reach;
  logic [ADDR_W-1:0] base_q;
  cfg_sel_e        sel;

  assign sel = cfg_sel_e'(cfg_sel);

  rxq_arbiter #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(ev_valid & {NCH{rst_n}}),
    .grant(ev_accept), .any(pick_any), .idx(pick_idx)
  );

  assign pick_type  = ev_type[pick_idx*TW +: TW];
  assign log_ev     = pick_any & ~slot_busy;
  assign drop_ev    = pick_any & slot_busy;
  assign frame_tick = log_ev && (pick_type == EV_FRAME);

  rxq_slot_ptr #(.ADDR_W(ADDR_W), .STEP(STEP)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .base_we(cfg_we && sel == SEL_BASE),
    .ptr_we(cfg_we && sel == SEL_PTR),
    .wdata(cfg_wdata), .adv(log_ev), .wrap(slot_wrap),
    .ptr(mem_addr), .base(base_q)
  );

  rxq_frame_gate #(.CNT_W(CNT_W), .THR_RST(THR_RST)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .thr_we(cfg_we && sel == SEL_THR),
    .thr_wdata(cfg_wdata[CNT_W-1:0]),
    .frame_tick(frame_tick), .ack(irq_ack),
    .reach(reach), .irq(irq)
  );

  assign mem_we    = log_ev;
  assign ovf_pulse = drop_ev;
  assign mem_wdata = pack_entry(8'(pick_idx), pick_type, slot_wrap);

  // R3: an owned slot is never written
  assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_busy |-> !mem_we);
  // R3: every accepted event either lands or is flagged
  assert_drop_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_accept) |-> (mem_we ^ ovf_pulse));
  // R1: a written record always carries the valid bit
  assert_valid_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata[31]);
  // R6: an interrupt only rises after a reach
  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(reach));
endmodule

// File: tb/sim_rxf_coalesce_queue.sv
module sim_rxf_coalesce_queue;
  localparam int CLK_PER = 10;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] ev_valid;
  logic [NCH*2-1:0] ev_type;
  logic [NCH-1:0] ev_accept;
  logic cfg_we;
  logic [1:0] cfg_sel;
  logic [15:0] cfg_wdata;
  logic slot_busy, slot_wrap;
  logic mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic ovf_pulse, irq, irq_ack;

  int total = 0;
  int bad = 0;
  logic s_we, s_ovf;
  logic [15:0] s_addr;
  logic [31:0] s_data;

  always #(CLK_PER/2) clk = ~clk;

  rxf_coalesce_queue u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_type(ev_type),
    .ev_accept(ev_accept), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .slot_busy(slot_busy), .slot_wrap(slot_wrap),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ovf_pulse(ovf_pulse), .irq(irq), .irq_ack(irq_ack)
  );

  // {valid[31:28], busy[27], wrap[26], grant[25:22], we[21], pad[20:16], addr[15:0]}
  localparam logic [31:0] TBL [8] = '{
    {4'b0110, 1'b0, 1'b0, 4'b0010, 1'b1, 5'd0, 16'h0100},
    {4'b1000, 1'b0, 1'b0, 4'b1000, 1'b1, 5'd0, 16'h0104},
    {4'b1111, 1'b1, 1'b0, 4'b0001, 1'b0, 5'd0, 16'h0108},
    {4'b1110, 1'b0, 1'b1, 4'b0010, 1'b1, 5'd0, 16'h0108},
    {4'b0000, 1'b0, 1'b0, 4'b0000, 1'b0, 5'd0, 16'h0100},
    {4'b0101, 1'b0, 1'b0, 4'b0001, 1'b1, 5'd0, 16'h0100},
    {4'b1100, 1'b0, 1'b0, 4'b0100, 1'b1, 5'd0, 16'h0104},
    {4'b1010, 1'b0, 1'b0, 4'b0010, 1'b1, 5'd0, 16'h0108}
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rec(input int ch, input int ty, input logic w);
    logic [31:0] r;
    r = 32'h8000_0000;
    r[30] = w;
    r[17:16] = 2'(ty);
    r[7:0] = 8'(ch);
    return r;
  endfunction

  task automatic idle();
    ev_valid = '0; ev_type = '0; cfg_we = 1'b0; cfg_sel = 2'd3; cfg_wdata = '0;
    slot_busy = 1'b0; slot_wrap = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd3;
  endtask

  task automatic ack_only();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  // one event; returns at the negedge after the clock edge that took it
  task automatic send(input int ch, input int ty, input logic busy, input logic ack);
    @(negedge clk);
    ev_valid = '0; ev_valid[ch] = 1'b1;
    ev_type = '0; ev_type[ch*2 +: 2] = 2'(ty);
    slot_busy = busy; irq_ack = ack;
    #1;
    s_we = mem_we; s_ovf = ovf_pulse; s_addr = mem_addr; s_data = mem_wdata;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(CLK_PER * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(irq == 0 && mem_we == 0 && ovf_pulse == 0 && ev_accept == 0 && mem_addr == 0,
          "R10 reset", {irq, mem_we, ovf_pulse, ev_accept, mem_addr}, 0);
    rst_n = 1'b1;

    // table walk: arbitration, records, pointer step/wrap/drop
    cfg(2'd0, 16'h0100);
    cfg(2'd1, 16'h0100);
    for (int v = 0; v < 8; v++) begin
      logic [31:0] t;
      int ch;
      t = TBL[v];
      ch = 0;
      for (int i = NCH - 1; i >= 0; i--) if (t[22+i]) ch = i;
      @(negedge clk);
      ev_valid = t[31:28]; ev_type = '0; slot_busy = t[27]; slot_wrap = t[26];
      #1;
      check(ev_accept == t[25:22], "R2 grant", 32'(ev_accept), 32'(t[25:22]));
      check(mem_we == t[21], "R1 write strobe", 32'(mem_we), 32'(t[21]));
      check(mem_addr == t[15:0], "R4 slot address", 32'(mem_addr), 32'(t[15:0]));
      check(ovf_pulse == (t[27] && t[31:28] != 0), "R3 overflow", 32'(ovf_pulse), 32'(t[27]));
      if (t[21]) check(mem_wdata == rec(ch, 0, t[26]), "R1 record", mem_wdata, rec(ch, 0, t[26]));
    end
    @(negedge clk);
    idle();

    // R1 record with nonzero type and channel
    do_reset();
    send(3, 2, 1'b0, 1'b0);
    check(s_data == rec(3, 2, 0), "R1 typed record", s_data, rec(3, 2, 0));

    // R5/R6: threshold 3, non-frame events ignored
    do_reset();
    send(0, 0, 1'b0, 1'b0);
    send(1, 1, 1'b0, 1'b0);
    send(2, 3, 1'b0, 1'b0);
    send(3, 0, 1'b0, 1'b0);
    check(irq == 0, "R5 no early irq", 32'(irq), 0);
    send(1, 2, 1'b0, 1'b0);
    check(irq == 0, "R5 other type no count", 32'(irq), 0);
    send(2, 0, 1'b0, 1'b0);
    check(irq == 1, "R6 irq on third frame", 32'(irq), 1);
    repeat (3) @(negedge clk);
    check(irq == 1, "R8 irq held", 32'(irq), 1);
    ack_only();
    check(irq == 0, "R8 ack clears", 32'(irq), 0);

    // R7: threshold rewrite deferred to next reload
    cfg(2'd2, 16'd1);
    send(0, 0, 1'b0, 1'b0);
    send(0, 0, 1'b0, 1'b0);
    check(irq == 0, "R7 old count still running", 32'(irq), 0);
    send(0, 0, 1'b0, 1'b0);
    check(irq == 1, "R7 reach at old threshold", 32'(irq), 1);
    ack_only();
    send(1, 0, 1'b0, 1'b0);
    check(irq == 1, "R7 new threshold after reload", 32'(irq), 1);

    // R8: reach while set, reach with ack
    send(2, 0, 1'b0, 1'b1);
    check(irq == 1, "R8 reach beats ack", 32'(irq), 1);
    ack_only();
    check(irq == 0, "R8 ack alone clears", 32'(irq), 0);

    // R3: dropped frame leaves counter and pointer unchanged
    send(0, 0, 1'b0, 1'b0);
    ack_only();
    begin
      logic [15:0] a0;
      #1 a0 = mem_addr;
      send(1, 0, 1'b1, 1'b0);
      check(s_ovf == 1 && s_we == 0, "R3 drop flagged", {s_ovf, s_we}, 2'b10);
      check(irq == 0, "R3 drop not counted", 32'(irq), 0);
      #1;
      check(mem_addr == a0, "R3 pointer held", 32'(mem_addr), 32'(a0));
    end
    send(1, 0, 1'b0, 1'b0);
    check(irq == 1, "R3 count intact after drop", 32'(irq), 1);
    ack_only();

    // R9: pointer load wins over advance
    @(negedge clk);
    ev_valid = 4'b0001; ev_type = '0;
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 16'h0200;
    @(negedge clk);
    idle();
    #1;
    check(mem_addr == 16'h0200, "R9 pointer load priority", 32'(mem_addr), 32'h200);
    cfg(2'd0, 16'h0300);
    @(negedge clk);
    ev_valid = 4'b0100; slot_wrap = 1'b1;
    @(negedge clk);
    idle();
    #1;
    check(mem_addr == 16'h0300, "R9 base load used by wrap", 32'(mem_addr), 32'h300);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule